// File: doc/BRIEF.md
# Oversampled Phase-Picking Bit Clock Recovery

This block recovers a bit clock and bit data from a line signal that arrives as two already-sliced pulse indications, one for positive marks and one for negative marks. It runs on a fast clock with thirteen ticks per nominal bit period. A free-running phase counter steps through those ticks. The block watches for rising pulse edges on either rail and compares where each edge lands with where it was expected. It then picks the tick at which every bit slot is sampled.

The sampling tick moves only when a pulse edge lands further from its expected position than a configurable deadband. The move waits for the next sample tick. With no pulses the tick stays where it is, so any run of zeros leaves the recovered clock running at the last chosen phase. The recovered data can be presented on two rails or merged into a single data bit. The recovered clock is formed so that the data is steady around the clock edge chosen for capture. In one mode a select input picks which clock edge that is. A slot in which both rails pulsed raises an error flag.

Top module: `crx_clock_recovery`

## Requirements
- R1: The phase counter steps by one on every clock and wraps from 12 to 0; the synchronous reset loads it with 0, and it never stops.
- R2: When a rising edge on either rail is seen while the counter holds k, and k lies more than DEADBAND (default 1) ticks away from the expected edge tick, the sample tick becomes (k + 6) mod 13. The expected edge tick is the sample tick minus 6, mod 13, and distances are folded into the range -6..+6. The change takes effect at the next sample tick.
- R3: An edge whose distance from the expected edge tick is within ±DEADBAND leaves the sample tick unchanged.
- R4: With no pulse edges, the sample tick is held indefinitely and the recovered clock keeps its period of 13 clocks and its position.
- R5: In its uninverted form, the recovered clock is high while the counter is between the sample tick and the sample tick + 6 (mod 13), and low for the other six values. Its rising edge therefore sits on the sample tick.
- R6: Each rail output is 1 when that rail was high on any clock since the previous sample tick, up to and including the current one. It updates on the sample tick, so it changes one clock after that tick and holds until the next one.
- R7: mode_sel 2'b00 and 2'b11 give two-rail output with rx_data low. mode_sel 2'b01 merges the rails: rx_data is 1 when either rail captured a pulse, and rx_pos and rx_neg are held low. In both cases rec_clk is uninverted.
- R8: mode_sel 2'b10 gives two-rail output. edge_sel = 0 leaves rec_clk uninverted, so data is captured on its rising edge. edge_sel = 1 inverts rec_clk, so data is captured on its falling edge.
- R9: rx_bpv is 1 for a slot in which both rails captured a pulse, and 0 otherwise, in every mode.
- R10: While rst_n is low at a clock edge, the counter goes to 0, the sample tick to 6, and all pending corrections and captured data are cleared. rx_pos, rx_neg, rx_data and rx_bpv are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, 13 ticks per bit |
| rst_n | input | 1 | Synchronous reset, active low |
| line_pos | input | 1 | Sliced positive-mark indication |
| line_neg | input | 1 | Sliced negative-mark indication |
| mode_sel | input | 2 | Output arrangement select (see R7, R8) |
| edge_sel | input | 1 | Capture-edge select, used when mode_sel is 2'b10 |
| rec_clk | output | 1 | Recovered bit clock |
| rx_pos | output | 1 | Recovered positive-rail bit |
| rx_neg | output | 1 | Recovered negative-rail bit |
| rx_data | output | 1 | Merged single-rail bit |
| rx_bpv | output | 1 | Both rails pulsed in the same slot |

## Verification
Every cycle, the assertions check the counter's step and wrap and the state that reset loads. They also check that the sample tick cannot move while no correction is pending and that captured data moves only on a sample tick. Further checks cover the error flag implying both rails, and the rail outputs staying low in merged mode. Whether an edge is classed as inside or outside the deadband, and where the clock then sits, can only be seen in the bench's scenarios. The same holds for phase retention across a long zero run and for the polarity chosen by edge_sel. Those scenarios measure the clock's level at given counter values after edges early, late and within tolerance.

// File: rtl/crx_pkg.sv
// Package: crx_pkg
// Shared types for the clock recovery block: the output arrangement select.
// Assumes nothing beyond a 2-bit mode input.
package crx_pkg;

    typedef enum logic [1:0] {
        CRX_DUAL     = 2'b00,
        CRX_MERGED   = 2'b01,
        CRX_HOST     = 2'b10,
        CRX_DUAL_ALT = 2'b11
    } crx_mode_e;

endpackage

// File: rtl/crx_phase_ctr.sv
// Module: crx_phase_ctr
// Free-running modulo-NPH tick counter that marks the position inside a
// nominal bit period. Assumes clk runs at NPH ticks per bit.
module crx_phase_ctr #(
    parameter int NPH = 13,
    parameter int PW  = $clog2(NPH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase_o
);

    localparam logic [PW-1:0] LAST = PW'(NPH - 1);

    // Step the tick position, wrapping at the end of the bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
        end else if (phase_o == LAST) begin
            phase_o <= '0;
        end else begin
            phase_o <= phase_o + 1'b1;
        end
    end

endmodule

// File: rtl/crx_phase_pick.sv
// Module: crx_phase_pick
// Detects rising pulse edges on either rail, measures how far each edge
// sits from where it was expected, and re-picks the sample tick when the
// distance exceeds DEADBAND. A correction waits for the next sample tick.
// Assumes the rails are already synchronous to clk.
module crx_phase_pick #(
    parameter int NPH      = 13,
    parameter int PW       = $clog2(NPH),
    parameter int DEADBAND = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pos_i,
    input  logic          neg_i,
    input  logic [PW-1:0] phase_i,
    output logic [PW-1:0] samp_o,
    output logic          pend_o,
    output logic          tick_o
);

    localparam int HALF = NPH / 2;

    logic          pos_d;
    logic          neg_d;
    logic          edge_hit;
    logic          far;
    logic [PW-1:0] tgt;
    logic [PW-1:0] pend_ph;
    int            ph_n;
    int            sp_n;
    int            exp_n;
    int            diff_n;
    int            dev_n;

    // Sample tick is reached when the counter equals the chosen phase.
    assign tick_o = (phase_i == samp_o);

    // Edge detection and signed distance from the expected edge tick.
    always_comb begin
        ph_n     = int'(phase_i);
        sp_n     = int'(samp_o);
        exp_n    = (sp_n + NPH - HALF) % NPH;
        diff_n   = (ph_n + NPH - exp_n) % NPH;
        dev_n    = (diff_n > HALF) ? (diff_n - NPH) : diff_n;
        edge_hit = (pos_i && !pos_d) || (neg_i && !neg_d);
        far      = edge_hit && ((dev_n > DEADBAND) || (dev_n < -DEADBAND));
        tgt      = PW'((ph_n + HALF) % NPH);
    end

    // Hold rail history, record corrections and apply them on a sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_d   <= 1'b0;
            neg_d   <= 1'b0;
            samp_o  <= PW'(HALF);
            pend_o  <= 1'b0;
            pend_ph <= '0;
        end else begin
            pos_d <= pos_i;
            neg_d <= neg_i;
            if (tick_o && pend_o) begin
                samp_o <= pend_ph;
            end
            if (far) begin
                pend_o  <= 1'b1;
                pend_ph <= tgt;
            end else if (tick_o) begin
                pend_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/crx_slot_capture.sv
// Module: crx_slot_capture
// Collects, per rail, whether any pulse was present during the current bit
// slot and transfers that to the outputs on the sample tick. Also flags a
// slot in which every rail pulsed. Assumes tick_i is high for one clock per slot.
module crx_slot_capture #(
    parameter int NRAIL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [NRAIL-1:0] rail_i,
    output logic [NRAIL-1:0] rail_o,
    output logic             bpv_o
);

    logic [NRAIL-1:0] seen_q;
    logic [NRAIL-1:0] nxt;

    // Per-rail value the slot closes with: history plus the tick cycle itself.
    for (genvar g = 0; g < NRAIL; g++) begin : g_rail
        assign nxt[g] = seen_q[g] | rail_i[g];
    end

    // Accumulate within the slot, publish and clear on the sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            rail_o <= '0;
            bpv_o  <= 1'b0;
        end else if (tick_i) begin
            rail_o <= nxt;
            bpv_o  <= &nxt;
            seen_q <= '0;
        end else begin
            seen_q <= nxt;
        end
    end

endmodule

// File: rtl/crx_clock_recovery.sv
// Module: crx_clock_recovery
// Top level: tick counter, phase picker and slot capture, plus the output
// arrangement mux and recovered clock shaping. Assumes line_pos/line_neg
// are sliced, synchronous indications and clk is NPH times the bit rate.
module crx_clock_recovery
    import crx_pkg::*;
#(
    parameter int NPH      = 13,
    parameter int DEADBAND = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_pos,
    input  logic       line_neg,
    input  logic [1:0] mode_sel,
    input  logic       edge_sel,
    output logic       rec_clk,
    output logic       rx_pos,
    output logic       rx_neg,
    output logic       rx_data,
    output logic       rx_bpv
);

    localparam int PW   = $clog2(NPH);
    localparam int HALF = NPH / 2;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] samp_q;
    logic          pend_q;
    logic          tick;
    logic [1:0]    cap_q;
    logic          bpv_q;
    logic          raw_clk;
    int            rel_n;
    crx_mode_e     mode;

    crx_phase_ctr #(.NPH(NPH), .PW(PW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase_q)
    );

    crx_phase_pick #(.NPH(NPH), .PW(PW), .DEADBAND(DEADBAND)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_i   (line_pos),
        .neg_i   (line_neg),
        .phase_i (phase_q),
        .samp_o  (samp_q),
        .pend_o  (pend_q),
        .tick_o  (tick)
    );

    crx_slot_capture #(.NRAIL(2)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .rail_i ({line_neg, line_pos}),
        .rail_o (cap_q),
        .bpv_o  (bpv_q)
    );

    assign mode   = crx_mode_e'(mode_sel);
    assign rx_bpv = bpv_q;

    // Clock is high for the first HALF+1 ticks counted from the sample tick.
    always_comb begin
        rel_n   = (int'(phase_q) + NPH - int'(samp_q)) % NPH;
        raw_clk = (rel_n <= HALF);
    end

    // Arrange the outputs and the clock polarity for the selected mode.
    always_comb begin
        rec_clk = raw_clk;
        rx_pos  = cap_q[0];
        rx_neg  = cap_q[1];
        rx_data = 1'b0;
        case (mode)
            CRX_MERGED: begin
                rx_pos  = 1'b0;
                rx_neg  = 1'b0;
                rx_data = cap_q[0] | cap_q[1];
            end
            CRX_HOST: begin
                rec_clk = edge_sel ? ~raw_clk : raw_clk;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/crx_clock_recovery_chk.sv
// Module: crx_clock_recovery_chk
// Cycle-level properties of the clock recovery block, attached by bind.
// Assumes the internal names of crx_clock_recovery.
module crx_clock_recovery_chk #(
    parameter int NPH = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [$clog2(NPH)-1:0]  phase,
    input logic [$clog2(NPH)-1:0]  samp,
    input logic                    pend,
    input logic                    tick,
    input logic [1:0]              cap,
    input logic [1:0]              mode_sel,
    input logic                    rx_pos,
    input logic                    rx_neg,
    input logic                    rx_data,
    input logic                    rx_bpv
);

    localparam int PW   = $clog2(NPH);
    localparam int HALF = NPH / 2;

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PW'(NPH - 1)) |=> (phase == '0));

    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PW'(NPH - 1)) |=> (phase == $past(phase) + 1'b1));

    p_samp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (samp < PW'(NPH)));

    p_samp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> $stable(samp));

    p_rail_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cap) && $stable(rx_bpv)));

    p_merged_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |-> (!rx_pos && !rx_neg));

    p_bpv_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bpv |-> (cap == 2'b11));

    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> ((phase == '0) && (samp == PW'(HALF)) && !pend &&
                    !rx_pos && !rx_neg && !rx_data && !rx_bpv));

endmodule

bind crx_clock_recovery crx_clock_recovery_chk #(.NPH(NPH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase_q),
    .samp     (samp_q),
    .pend     (pend_q),
    .tick     (tick),
    .cap      (cap_q),
    .mode_sel (mode_sel),
    .rx_pos   (rx_pos),
    .rx_neg   (rx_neg),
    .rx_data  (rx_data),
    .rx_bpv   (rx_bpv)
);

// File: tb/crx_clock_recovery_tb.sv
// Bench: table of per-slot vectors followed by directed phase and reset tests.
module crx_clock_recovery_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pos = 1'b0;
    logic       neg = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       esel = 1'b0;
    logic       rec_clk, rx_pos, rx_neg, rx_data, rx_bpv;

    int  checks = 0;
    int  fails  = 0;
    int  bph    = 0;
    bit  done   = 1'b0;

    crx_clock_recovery u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_pos (pos),
        .line_neg (neg),
        .mode_sel (mode),
        .edge_sel (esel),
        .rec_clk  (rec_clk),
        .rx_pos   (rx_pos),
        .rx_neg   (rx_neg),
        .rx_data  (rx_data),
        .rx_bpv   (rx_bpv)
    );

    always #5 clk = ~clk;

    // Bench copy of the tick position, per R1 (0 after reset, +1 mod 13).
    always @(posedge clk) bph <= (!rst_n) ? 0 : ((bph == 12) ? 0 : bph + 1);

    // Fields: p n mode[1:0] esel | pos neg data bpv clk (clk sampled at tick 10).
    localparam logic [9:0] VEC [12] = '{
        10'b1_0_00_0_10001,
        10'b0_1_00_0_01001,
        10'b1_1_00_0_11011,
        10'b0_0_00_0_00001,
        10'b1_0_01_0_00101,
        10'b0_1_01_0_00101,
        10'b1_1_01_0_00111,
        10'b0_0_01_0_00001,
        10'b1_0_10_0_10001,
        10'b0_1_10_1_01000,
        10'b1_1_11_0_11011,
        10'b0_0_10_1_00000
    };

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_ph(int k);
        do @(negedge clk); while (bph != k);
    endtask

    // Three-clock pulse starting while the tick position is 'start'.
    task automatic pulse(int start, logic p, logic n);
        wait_ph(start);
        pos = p;
        neg = n;
        repeat (3) @(negedge clk);
        pos = 1'b0;
        neg = 1'b0;
    endtask

    task automatic chk_idle_outputs(string tag);
        chk({tag, " rx_pos"},  int'(rx_pos),  0);
        chk({tag, " rx_neg"},  int'(rx_neg),  0);
        chk({tag, " rx_data"}, int'(rx_data), 0);
        chk({tag, " rx_bpv"},  int'(rx_bpv),  0);
        chk({tag, " rec_clk"}, int'(rec_clk), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle_outputs("R10 initial reset");
        rst_n = 1'b1;

        // Vector walk: edges at tick 0 (on time), sample tick 6.
        for (int i = 0; i < 12; i++) begin
            wait_ph(0);
            mode = VEC[i][7:6];
            esel = VEC[i][5];
            pos  = VEC[i][9];
            neg  = VEC[i][8];
            repeat (3) @(negedge clk);
            pos = 1'b0;
            neg = 1'b0;
            wait_ph(10);
            chk($sformatf("R6 R7 R8 vec%0d rx_pos", i),  int'(rx_pos),  int'(VEC[i][4]));
            chk($sformatf("R6 R7 vec%0d rx_neg", i),     int'(rx_neg),  int'(VEC[i][3]));
            chk($sformatf("R7 vec%0d rx_data", i),       int'(rx_data), int'(VEC[i][2]));
            chk($sformatf("R9 vec%0d rx_bpv", i),        int'(rx_bpv),  int'(VEC[i][1]));
            chk($sformatf("R5 R8 vec%0d rec_clk", i),    int'(rec_clk), int'(VEC[i][0]));
        end

        mode = 2'b00;
        esel = 1'b0;

        // R1 R5: clock edge sits on sample tick 6.
        wait_ph(5);  chk("R1 R5 low before tick", int'(rec_clk), 0);
        wait_ph(6);  chk("R1 R5 high at tick",    int'(rec_clk), 1);
        wait_ph(12); chk("R5 high at tick+6",     int'(rec_clk), 1);

        // R3: edge one tick late stays inside the deadband.
        pulse(1, 1'b1, 1'b0);
        wait_ph(10); chk("R3 R6 data captured", int'(rx_pos), 1);
        wait_ph(5);  chk("R3 clock unchanged low",  int'(rec_clk), 0);
        wait_ph(6);  chk("R3 clock unchanged high", int'(rec_clk), 1);

        // R2: edge three ticks late moves sample tick to 9.
        pulse(3, 1'b1, 1'b0);
        wait_ph(8);  chk("R2 R6 old slot data",   int'(rx_pos), 1);
        chk("R2 late edge clock low at 8",        int'(rec_clk), 0);
        wait_ph(9);  chk("R2 late edge clock high at 9", int'(rec_clk), 1);
        wait_ph(11); chk("R6 slot at new tick empty", int'(rx_pos), 0);

        // R4: long zero run keeps the new phase.
        repeat (20 * 13) @(negedge clk);
        wait_ph(8);  chk("R4 held clock low at 8",   int'(rec_clk), 0);
        wait_ph(9);  chk("R4 held clock high at 9",  int'(rec_clk), 1);
        chk("R4 zero run data", int'(rx_pos), 0);

        // R2: edge two ticks early moves sample tick from 9 to 7.
        pulse(1, 1'b0, 1'b1);
        wait_ph(10);
        wait_ph(6);  chk("R2 early edge clock low at 6", int'(rec_clk), 0);
        chk("R6 neg held until new tick", int'(rx_neg), 1);
        wait_ph(7);  chk("R2 early edge clock high at 7", int'(rec_clk), 1);
        wait_ph(8);  chk("R6 neg cleared after tick", int'(rx_neg), 0);

        // R10: reset mid-run restores sample tick 6.
        pulse(0, 1'b1, 1'b1);
        wait_ph(9);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle_outputs("R10 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        wait_ph(5);  chk("R10 R1 clock low at 5",  int'(rec_clk), 0);
        wait_ph(6);  chk("R10 R1 clock high at 6", int'(rec_clk), 1);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule